// File: doc/BRIEF.md
# Single-Bit ECC Error Status Tracker

This block gathers single-bit ECC error strobes from every RAM transfer path of a message-buffer communication controller and keeps them in one sticky status word. The paths are: the header scan over the message buffers, message RAM to transient buffer, transient buffer to protocol engine (one strobe per channel), transient buffer to message RAM (split into a header-read error and a transient-read error), message RAM to output buffer, and host reads of the output buffer. Events that concern a specific message buffer also record that buffer's number together with a valid flag.

When error correction is turned off, the block also drives the fallback controls for the transfer in flight in the same cycle. These controls skip a buffer, drop a frame, force a frame CRC to zero, hold back a data-section write, block a network-management vector update, or mark output-buffer contents as unusable. The surrounding transfer logic applies them. The host clears status bits by writing ones to their positions.

Top module: `sbe_status_tracker`

## Requirements
- R1: After reset `status`, `fb_idx` and all response outputs are zero. The status layout for NCH channels is: bit 0 message-RAM flag, bits 1..NCH transient-buffer flags (bit 1 = channel 0), bit NCH+1 output-buffer flag, bit NCH+2 faulty-buffer-valid flag.
- R2: `scan_err` sets the message-RAM flag and the valid flag and supplies `scan_idx`. With `corr_en`=0, `skip_buf` is high in the same cycle.
- R3: `m2t_err` sets the message-RAM flag and the valid flag and supplies `m2t_idx`. With `corr_en`=0, `drop_frame` and `crc_zero` are high in the same cycle.
- R4: `t2p_err[c]` sets only transient flag c and leaves the valid flag and `fb_idx` unchanged. With `corr_en`=0, `crc_zero` is high in the same cycle.
- R5: `t2m_hdr_err` sets the message-RAM flag and the valid flag and supplies `t2m_idx`. With `corr_en`=0, `data_hold` is high in the same cycle.
- R6: `t2m_tb_err` sets the transient flag of channel `t2m_ch` and the valid flag and supplies `t2m_idx`. It never raises `data_hold`. With `corr_en`=0 and `t2m_nm`=1, `nmv_block` is high in the same cycle.
- R7: `m2o_err` sets the message-RAM flag and the valid flag and supplies `m2o_idx`. With `corr_en`=0, `obuf_bad` is high in the same cycle.
- R8: `host_rd_err` sets only the output-buffer flag.
- R9: Flags are sticky. A flag clears only on a cycle with `clr_we`=1 and a 1 in its bit of `clr_mask`. A set in the same cycle wins over a clear.
- R10: `fb_idx` loads only when the valid flag is 0 or is being cleared in that cycle. Otherwise the first captured index is held.
- R11: When several index events arrive in one cycle, the index comes from the first of: scan, message RAM to transient, transient-to-message-RAM header read, message RAM to output, transient-to-message-RAM transient read.
- R12: With `corr_en`=1, all six response outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_en | input | 1 | Single-bit correction enabled |
| scan_err | input | 1 | Error during header scan |
| scan_idx | input | IDX_W | Buffer being scanned |
| m2t_err | input | 1 | Error, message RAM to transient buffer |
| m2t_idx | input | IDX_W | Buffer of that transfer |
| t2p_err | input | NCH | Error, transient buffer to protocol engine, per channel |
| t2m_hdr_err | input | 1 | Header-read error, transient buffer to message RAM |
| t2m_tb_err | input | 1 | Transient-read error, transient buffer to message RAM |
| t2m_ch | input | CH_W | Channel of the transient-to-message-RAM transfer |
| t2m_idx | input | IDX_W | Target buffer of that transfer |
| t2m_nm | input | 1 | Frame carries network-management data |
| m2o_err | input | 1 | Error, message RAM to output buffer |
| m2o_idx | input | IDX_W | Buffer of that transfer |
| host_rd_err | input | 1 | Error on a host read of the output buffer |
| clr_we | input | 1 | Host clear strobe |
| clr_mask | input | NCH+3 | Write-one-to-clear mask |
| status | output | NCH+3 | Sticky status flags |
| fb_idx | output | IDX_W | Captured faulty buffer number |
| skip_buf | output | 1 | Skip this buffer's transfer |
| drop_frame | output | 1 | Do not send the frame |
| crc_zero | output | 1 | Force the CRC of the frame in flight to zero |
| data_hold | output | 1 | Suppress the data-section write |
| nmv_block | output | 1 | Do not update the network-management vector |
| obuf_bad | output | 1 | Output buffer contents are unusable |

## Verification
The six response outputs are combinational, so the bench samples them 1 ns after it drives the strobes, before the next rising edge. Status flags and `fb_idx` are registered once. The bench releases the strobes just after the capturing edge and reads the status at the following falling edge, exactly one cycle after the stimulus. Each expected status word is formed in the bench by masking, ORing and a priority pick over the strobes applied in that cycle, then compared at that falling edge.

// File: rtl/sbe_trk_pkg.sv
package sbe_trk_pkg;
   // index-event source order; lower number wins the index capture
   localparam int SRC_SCAN    = 0;
   localparam int SRC_M2T     = 1;
   localparam int SRC_T2M_HDR = 2;
   localparam int SRC_M2O     = 3;
   localparam int SRC_T2M_TB  = 4;
   localparam int NSRC        = 5;

   function automatic int stat_width(input int nch);
      return nch + 3;
   endfunction
   function automatic int ob_bit(input int nch);
      return nch + 1;
   endfunction
   function automatic int vld_bit(input int nch);
      return nch + 2;
   endfunction
endpackage

// File: rtl/sbe_trk_flags.sv
module sbe_trk_flags #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      q[b] <= 1'b0;
         else if (set[b]) q[b] <= 1'b1;
         else if (clr[b]) q[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/sbe_trk_capture.sv
module sbe_trk_capture #(
   parameter int IDX_W = 7,
   parameter int NSRC  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_vld,
   input  logic [IDX_W-1:0] src_idx [NSRC],
   input  logic             load_ok,
   output logic [IDX_W-1:0] fb_idx
);
   logic [IDX_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int s = NSRC - 1; s >= 0; s--) begin
         if (src_vld[s]) pick = src_idx[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    fb_idx <= '0;
      else if (|src_vld && load_ok)  fb_idx <= pick;
   end
endmodule

// File: rtl/sbe_trk_resp.sv
module sbe_trk_resp #(
   parameter int NCH = 2
) (
   input  logic           corr_en,
   input  logic           scan_err,
   input  logic           m2t_err,
   input  logic [NCH-1:0] t2p_err,
   input  logic           t2m_hdr_err,
   input  logic           t2m_tb_err,
   input  logic           t2m_nm,
   input  logic           m2o_err,
   output logic           skip_buf,
   output logic           drop_frame,
   output logic           crc_zero,
   output logic           data_hold,
   output logic           nmv_block,
   output logic           obuf_bad
);
   logic fallback;
   assign fallback   = !corr_en;
   assign skip_buf   = fallback && scan_err;
   assign drop_frame = fallback && m2t_err;
   assign crc_zero   = fallback && (m2t_err || (|t2p_err));
   assign data_hold  = fallback && t2m_hdr_err;
   assign nmv_block  = fallback && t2m_tb_err && t2m_nm;
   assign obuf_bad   = fallback && m2o_err;
endmodule

// File: rtl/sbe_status_tracker.sv
module sbe_status_tracker
   import sbe_trk_pkg::*;
#(
   parameter int IDX_W  = 7,
   parameter int NCH    = 2,
   parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   parameter int STAT_W = NCH + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              corr_en,
   input  logic              scan_err,
   input  logic [IDX_W-1:0]  scan_idx,
   input  logic              m2t_err,
   input  logic [IDX_W-1:0]  m2t_idx,
   input  logic [NCH-1:0]    t2p_err,
   input  logic              t2m_hdr_err,
   input  logic              t2m_tb_err,
   input  logic [CH_W-1:0]   t2m_ch,
   input  logic [IDX_W-1:0]  t2m_idx,
   input  logic              t2m_nm,
   input  logic              m2o_err,
   input  logic [IDX_W-1:0]  m2o_idx,
   input  logic              host_rd_err,
   input  logic              clr_we,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] status,
   output logic [IDX_W-1:0]  fb_idx,
   output logic              skip_buf,
   output logic              drop_frame,
   output logic              crc_zero,
   output logic              data_hold,
   output logic              nmv_block,
   output logic              obuf_bad
);
   localparam int OB_B = ob_bit(NCH);
   localparam int VL_B = vld_bit(NCH);

   initial begin : p_param_chk
      assert (IDX_W >= 1 && IDX_W <= 16) else $error("IDX_W out of range");
      assert (NCH >= 1 && NCH <= 4) else $error("NCH out of range");
      assert (STAT_W == stat_width(NCH)) else $error("STAT_W must be NCH+3");
   end

   logic [NSRC-1:0]   src_vld;
   logic [IDX_W-1:0]  src_idx [NSRC];
   logic [STAT_W-1:0] set_v;
   logic [STAT_W-1:0] clr_v;
   logic [NCH-1:0]    tb_set;

   assign src_vld[SRC_SCAN]    = scan_err;
   assign src_vld[SRC_M2T]     = m2t_err;
   assign src_vld[SRC_T2M_HDR] = t2m_hdr_err;
   assign src_vld[SRC_M2O]     = m2o_err;
   assign src_vld[SRC_T2M_TB]  = t2m_tb_err;
   assign src_idx[SRC_SCAN]    = scan_idx;
   assign src_idx[SRC_M2T]     = m2t_idx;
   assign src_idx[SRC_T2M_HDR] = t2m_idx;
   assign src_idx[SRC_M2O]     = m2o_idx;
   assign src_idx[SRC_T2M_TB]  = t2m_idx;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign tb_set[c] = t2p_err[c] || (t2m_tb_err && (t2m_ch == CH_W'(c)));
   end

   assign set_v[0]        = scan_err || m2t_err || t2m_hdr_err || m2o_err;
   assign set_v[NCH:1]    = tb_set;
   assign set_v[OB_B]     = host_rd_err;
   assign set_v[VL_B]     = |src_vld;
   assign clr_v           = clr_we ? clr_mask : '0;

   sbe_trk_flags #(.W(STAT_W)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v),
      .clr   (clr_v),
      .q     (status)
   );

   sbe_trk_capture #(.IDX_W(IDX_W), .NSRC(NSRC)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_vld (src_vld),
      .src_idx (src_idx),
      .load_ok (!status[VL_B] || clr_v[VL_B]),
      .fb_idx  (fb_idx)
   );

   sbe_trk_resp #(.NCH(NCH)) u_resp (
      .corr_en     (corr_en),
      .scan_err    (scan_err),
      .m2t_err     (m2t_err),
      .t2p_err     (t2p_err),
      .t2m_hdr_err (t2m_hdr_err),
      .t2m_tb_err  (t2m_tb_err),
      .t2m_nm      (t2m_nm),
      .m2o_err     (m2o_err),
      .skip_buf    (skip_buf),
      .drop_frame  (drop_frame),
      .crc_zero    (crc_zero),
      .data_hold   (data_hold),
      .nmv_block   (nmv_block),
      .obuf_bad    (obuf_bad)
   );
endmodule

// File: rtl/sbe_trk_chk.sv
module sbe_trk_chk #(
   parameter int IDX_W = 7,
   parameter int NCH   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              corr_en,
   input logic              scan_err,
   input logic              m2t_err,
   input logic [NCH-1:0]    t2p_err,
   input logic              t2m_hdr_err,
   input logic              t2m_tb_err,
   input logic              m2o_err,
   input logic              host_rd_err,
   input logic              clr_we,
   input logic [NCH+2:0]    clr_mask,
   input logic [NCH+2:0]    status,
   input logic [IDX_W-1:0]  fb_idx,
   input logic              skip_buf,
   input logic              drop_frame,
   input logic              crc_zero,
   input logic              data_hold,
   input logic              nmv_block,
   input logic              obuf_bad
);
   localparam int VB = NCH + 2;
   localparam int OB = NCH + 1;

   logic [NCH+2:0] clr_seen;
   logic           idx_evt;
   assign clr_seen = clr_we ? clr_mask : '0;
   assign idx_evt  = scan_err || m2t_err || t2m_hdr_err || t2m_tb_err || m2o_err;

   a_r2_scan_flags: assert property (@(posedge clk) disable iff (!rst_n)
      scan_err |=> (status[0] && status[VB]));

   a_r3_drop_kills_crc: assert property (@(posedge clk) disable iff (!rst_n)
      drop_frame |-> crc_zero);

   a_r4_valid_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      ((|t2p_err) && !idx_evt && !clr_seen[VB]) |=> (status[VB] == $past(status[VB])));

   a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (t2m_tb_err && !t2m_hdr_err) |-> !data_hold);

   a_r7_obuf_flag: assert property (@(posedge clk) disable iff (!rst_n)
      m2o_err |=> status[0]);

   a_r8_host_flag: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_err |=> status[OB]);

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~status & $past(status) & ~$past(clr_seen)) == '0));

   a_r10_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (status[VB] && !clr_seen[VB]) |=> $stable(fb_idx));

   a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      corr_en |-> !(skip_buf || drop_frame || crc_zero || data_hold || nmv_block || obuf_bad));
endmodule

bind sbe_status_tracker sbe_trk_chk #(.IDX_W(IDX_W), .NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .corr_en     (corr_en),
   .scan_err    (scan_err),
   .m2t_err     (m2t_err),
   .t2p_err     (t2p_err),
   .t2m_hdr_err (t2m_hdr_err),
   .t2m_tb_err  (t2m_tb_err),
   .m2o_err     (m2o_err),
   .host_rd_err (host_rd_err),
   .clr_we      (clr_we),
   .clr_mask    (clr_mask),
   .status      (status),
   .fb_idx      (fb_idx),
   .skip_buf    (skip_buf),
   .drop_frame  (drop_frame),
   .crc_zero    (crc_zero),
   .data_hold   (data_hold),
   .nmv_block   (nmv_block),
   .obuf_bad    (obuf_bad)
);

// File: tb/sbe_status_tracker_test.sv
module sbe_status_tracker_test;
   localparam int IDX_W = 7;
   localparam int NCH   = 2;
   localparam int SW    = NCH + 3;
   localparam int VB    = NCH + 2;
   localparam int OB    = NCH + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic corr_en = 1'b0;
   logic scan_err = 1'b0, m2t_err = 1'b0, t2m_hdr_err = 1'b0, t2m_tb_err = 1'b0;
   logic m2o_err = 1'b0, host_rd_err = 1'b0, t2m_nm = 1'b0, clr_we = 1'b0;
   logic [IDX_W-1:0] scan_idx = '0, m2t_idx = '0, t2m_idx = '0, m2o_idx = '0;
   logic [NCH-1:0] t2p_err = '0;
   logic [0:0] t2m_ch = '0;
   logic [SW-1:0] clr_mask = '0;
   logic [SW-1:0] status;
   logic [IDX_W-1:0] fb_idx;
   logic skip_buf, drop_frame, crc_zero, data_hold, nmv_block, obuf_bad;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [SW-1:0] exp_st = '0;
   logic [IDX_W-1:0] exp_idx = '0;

   always #5 clk = ~clk;

   sbe_status_tracker #(.IDX_W(IDX_W), .NCH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .corr_en(corr_en),
      .scan_err(scan_err), .scan_idx(scan_idx),
      .m2t_err(m2t_err), .m2t_idx(m2t_idx), .t2p_err(t2p_err),
      .t2m_hdr_err(t2m_hdr_err), .t2m_tb_err(t2m_tb_err), .t2m_ch(t2m_ch),
      .t2m_idx(t2m_idx), .t2m_nm(t2m_nm), .m2o_err(m2o_err), .m2o_idx(m2o_idx),
      .host_rd_err(host_rd_err), .clr_we(clr_we), .clr_mask(clr_mask),
      .status(status), .fb_idx(fb_idx), .skip_buf(skip_buf), .drop_frame(drop_frame),
      .crc_zero(crc_zero), .data_hold(data_hold), .nmv_block(nmv_block), .obuf_bad(obuf_bad)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic release_inputs();
      scan_err = 0; m2t_err = 0; t2m_hdr_err = 0; t2m_tb_err = 0; m2o_err = 0;
      host_rd_err = 0; t2p_err = '0; clr_we = 0; clr_mask = '0; t2m_nm = 0;
   endtask

   // inputs are driven just after a falling edge; ends at the next falling edge
   task automatic step(input string req);
      logic [5:0] exp_rsp;
      logic [SW-1:0] setv, clrv;
      logic anyidx, fb;
      #1;
      fb = !corr_en;
      exp_rsp = {fb & scan_err, fb & m2t_err, fb & (m2t_err | (|t2p_err)),
                 fb & t2m_hdr_err, fb & t2m_tb_err & t2m_nm, fb & m2o_err};
      check({req, " resp"}, 32'({skip_buf, drop_frame, crc_zero, data_hold, nmv_block, obuf_bad}),
            32'(exp_rsp));
      setv = '0;
      setv[0] = scan_err | m2t_err | t2m_hdr_err | m2o_err;
      for (int c = 0; c < NCH; c++)
         setv[1 + c] = t2p_err[c] | (t2m_tb_err & (int'(t2m_ch) == c));
      setv[OB] = host_rd_err;
      anyidx = scan_err | m2t_err | t2m_hdr_err | m2o_err | t2m_tb_err;
      setv[VB] = anyidx;
      clrv = clr_we ? clr_mask : '0;
      if (anyidx && (!exp_st[VB] || clrv[VB])) begin
         if (scan_err)         exp_idx = scan_idx;
         else if (m2t_err)     exp_idx = m2t_idx;
         else if (t2m_hdr_err) exp_idx = t2m_idx;
         else if (m2o_err)     exp_idx = m2o_idx;
         else                  exp_idx = t2m_idx;
      end
      exp_st = (exp_st & ~clrv) | setv;
      @(posedge clk); #1;
      release_inputs();
      @(negedge clk);
      check({req, " status"}, 32'(status), 32'(exp_st));
      check({req, " index"}, 32'(fb_idx), 32'(exp_idx));
   endtask

   task automatic clear_all();
      clr_we = 1; clr_mask = '1;
      step("R9 clear");
   endtask

   task automatic set_src(input int s, input logic [IDX_W-1:0] v);
      case (s)
         0: begin scan_err = 1; scan_idx = v; end
         1: begin m2t_err = 1; m2t_idx = v; end
         2: begin t2m_hdr_err = 1; t2m_idx = v; end
         3: begin m2o_err = 1; m2o_idx = v; end
         default: begin t2m_tb_err = 1; t2m_idx = v; end
      endcase
   endtask

   initial begin
      #200000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [IDX_W-1:0] vals [4];
      vals[0] = 7'd0; vals[1] = 7'd1; vals[2] = 7'd42; vals[3] = 7'd127;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 status", 32'(status), 32'd0);
      check("R1 index", 32'(fb_idx), 32'd0);
      check("R1 resp", 32'({skip_buf, drop_frame, crc_zero, data_hold, nmv_block, obuf_bad}), 32'd0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3 R5 R6 R7 R12: every index source, both correction modes, several indices
      for (int cm = 0; cm < 2; cm++) begin
         for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 4; k++) begin
               clear_all();
               corr_en = cm[0];
               t2m_ch = k[0];
               t2m_nm = k[1];
               set_src(s, vals[k]);
               case (s)
                  0: step("R2 scan");
                  1: step("R3 m2t");
                  2: step("R5 t2m hdr");
                  3: step("R7 m2o");
                  default: step("R6 t2m tb");
               endcase
            end
         end
      end

      // R4 per-channel transient path; R8 host read; R12 responses idle
      for (int cm = 0; cm < 2; cm++) begin
         for (int c = 0; c < NCH; c++) begin
            clear_all();
            corr_en = cm[0];
            t2p_err[c] = 1'b1;
            step("R4 t2p channel");
         end
         corr_en = cm[0];
         host_rd_err = 1;
         step("R8 host read");
      end
      corr_en = 0;

      // R11 priority over all strobe combinations
      for (int m = 1; m < 32; m++) begin
         clear_all();
         for (int s = 0; s < 5; s++)
            if (m[s]) set_src(s, 7'(10 + s));
         if (m[2] && m[4]) t2m_idx = 7'd12;
         step("R11 priority");
      end

      // R10 first index held, reload when valid cleared in the same cycle
      clear_all();
      set_src(3, 7'd5); step("R10 first");
      set_src(0, 7'd9); step("R10 held");
      clr_we = 1; clr_mask = '0; clr_mask[VB] = 1'b1;
      set_src(1, 7'd33); step("R10 reload");

      // R9 partial clear, sticky bits, set over clear
      host_rd_err = 1; t2p_err = 2'b10; step("R9 build");
      clr_we = 1; clr_mask = 5'b00001; step("R9 clear mr only");
      step("R9 idle sticky");
      clr_we = 1; clr_mask = 5'b01000; host_rd_err = 1; step("R9 set wins");
      clr_we = 0; clr_mask = '1; step("R9 mask without strobe");
      clear_all();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule